// File: doc/BRIEF.md
# Receive Ring Buffer Writer

This block places incoming frames into a circular receive area of local packet memory. The area is split into 256-byte pages and runs from a programmable first page up to, but not including, a programmable end page. Each frame that is taken in occupies a whole number of pages. It starts on a page boundary with a four-byte header: a status byte, the page number where the following frame will start, and the stored length as two bytes, low byte first. The frame bytes follow the header directly. The block keeps the write page pointer and moves it forward after each frame. It also reports when the free space before the host's read page is too small for a maximum-size frame, and in that case it turns new frames away.

Frame bytes arrive one per valid cycle, with a first-byte marker and a last-byte marker. The host supplies the ring limits, its read (boundary) page and a stop flag. It can also load the write page pointer directly. Data is written to memory as it arrives. Short frames are then padded with zeros, and the header is written last, once the length is known. A one-cycle done pulse marks the cycle in which the new pointer and status are visible.

States: `ST_IDLE` waits for a first byte. `ST_DATA` stores frame bytes. `ST_SKIP` swallows the rest of a refused frame. `ST_PAD` writes zero fill. `ST_HDR` writes the four header bytes. `ST_DONE` is the one-cycle commit state, and it also takes a new first byte. The transitions are:
- IDLE/DONE to DATA on an accepted first byte.
- IDLE/DONE to PAD or HDR on an accepted one-byte frame.
- IDLE/DONE to SKIP on a refused first byte that is not also the last.
- DATA to PAD or HDR on the last byte.
- SKIP to IDLE on the last byte.
- PAD to HDR when the minimum size is reached.
- HDR to DONE after the fourth header byte.
- DONE to IDLE when no new frame starts.

Top module: `rxr_ring_writer`

## Requirements
- R1: Every memory write lands at a page in [start_pg, stop_pg). While frame bytes and padding are written, the address that would equal stop_pg*256 is replaced by start_pg*256.
- R2: With C = cur_pg*256 and B = bnd_pg*256, free space is B-C when C<B, and otherwise (stop_pg-start_pg)*256-(C-B). ring_full is high exactly when free space is below 1518 bytes.
- R3: A first byte seen in IDLE or DONE while stopped=1 or ring_full=1 is refused. frame_drop pulses in that cycle, the frame causes no memory writes, cur_pg is unchanged, and the following bytes are discarded up to and including the last-byte marker.
- R4: The bytes of an accepted frame are stored in order, starting at cur_pg*256+4.
- R5: A frame shorter than 60 bytes is extended with zero bytes to 60 stored bytes.
- R6: The header at cur_pg*256 holds byte 0 = status, byte 1 = next page, byte 2 = length bits 7:0, byte 3 = length bits 15:8. The length is the stored size (after padding) plus 4.
- R7: The next page is cur_pg + (length+4+255)/256, minus (stop_pg-start_pg) if that sum is at least stop_pg.
- R8: The status byte is 0x01, with bit 5 (0x20) also set when bit 0 of the frame's first byte is 1.
- R9: rx_done is a one-cycle pulse. In that cycle cur_pg already holds the next page and rx_status holds the frame's status byte.
- R10: A first byte presented in the rx_done cycle is judged against the updated cur_pg and is taken in or refused without loss.
- R11: A cur_set pulse with no commit in the same cycle loads cur_val into cur_pg, visible after that clock edge.
- R12: After reset, cur_pg is 0, rx_status is 0, and mem_we, rx_done and frame_drop are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | The present byte is the first of a frame |
| in_eof | input | 1 | The present byte is the last of a frame |
| in_data | input | 8 | Frame byte |
| stopped | input | 1 | Receiver stopped; new frames are refused |
| start_pg | input | 8 | First page of the ring |
| stop_pg | input | 8 | Page just past the ring |
| bnd_pg | input | 8 | Host read (boundary) page |
| cur_set | input | 1 | Load the write page pointer |
| cur_val | input | 8 | Value loaded by cur_set |
| mem_we | output | 1 | Memory byte write strobe |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| cur_pg | output | 8 | Write page pointer |
| rx_status | output | 8 | Status of the last stored frame |
| rx_done | output | 1 | One-cycle frame-stored pulse |
| ring_full | output | 1 | Free space below one maximum frame |
| frame_drop | output | 1 | One-cycle frame-refused pulse |

## Verification
Two things can happen in the same cycle: the commit of one frame, which advances cur_pg and raises rx_done, and the arrival of the next frame's first byte. The acceptance of that byte is decided on the pointer that has just moved. The bench provokes this by starting a frame in the very cycle rx_done is seen, on a random half of the frames. During those frames the boundary page sometimes lags, so the ring fills up and some of these same-cycle starts must be refused. Each case is judged against a bench model of free space and next page: the refusal pulse and the full flag in the start cycle, the header found at the new page, and the count of memory writes the frame caused.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_SKIP,
        ST_PAD,
        ST_HDR,
        ST_DONE
    } rxr_state_e;

    localparam logic [7:0] RXS_GOOD  = 8'h01;
    localparam logic [7:0] RXS_GROUP = 8'h20;

    function automatic logic [7:0] rxr_status(input logic group_bit);
        return group_bit ? (RXS_GOOD | RXS_GROUP) : RXS_GOOD;
    endfunction

endpackage

// File: rtl/rxr_space_calc.sv
module rxr_space_calc #(
    parameter int PAGE_W    = 8,
    parameter int OFF_W     = 8,
    parameter int NEED_BYTES = 1518
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] bnd_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    output logic              full
);
    localparam int SUM_W = PAGE_W + 1 + OFF_W;

    logic [PAGE_W:0] avail_pg;
    logic [SUM_W-1:0] avail_bytes;

    always_comb begin
        if (cur_pg < bnd_pg) begin
            avail_pg = {1'b0, bnd_pg} - {1'b0, cur_pg};
        end else begin
            avail_pg = ({1'b0, stop_pg} - {1'b0, start_pg})
                     - ({1'b0, cur_pg} - {1'b0, bnd_pg});
        end
        avail_bytes = {avail_pg, {OFF_W{1'b0}}};
        full = avail_bytes < SUM_W'(NEED_BYTES);
    end

endmodule

// File: rtl/rxr_next_calc.sv
module rxr_next_calc #(
    parameter int PAGE_W    = 8,
    parameter int OFF_W     = 8,
    parameter int LEN_W     = 16,
    parameter int CRC_BYTES = 4
) (
    input  logic [PAGE_W-1:0] cur_pg,
    input  logic [PAGE_W-1:0] start_pg,
    input  logic [PAGE_W-1:0] stop_pg,
    input  logic [LEN_W-1:0]  total_len,
    output logic [PAGE_W-1:0] next_pg
);
    localparam int PAGE_BYTES = 1 << OFF_W;

    logic [PAGE_W:0] span_pg;
    logic [PAGE_W:0] raw_pg;

    always_comb begin
        // Round up the stored length plus the trailing check bytes to pages.
        span_pg = (PAGE_W+1)'(({1'b0, total_len}
                   + (LEN_W+1)'(CRC_BYTES + PAGE_BYTES - 1)) >> OFF_W);
        raw_pg  = {1'b0, cur_pg} + span_pg;
        if (raw_pg >= {1'b0, stop_pg}) begin
            raw_pg = raw_pg - ({1'b0, stop_pg} - {1'b0, start_pg});
        end
        next_pg = raw_pg[PAGE_W-1:0];
    end

endmodule

// File: rtl/rxr_addr_step.sv
module rxr_addr_step #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic [PAGE_W+OFF_W-1:0] addr,
    input  logic [PAGE_W-1:0]       start_pg,
    input  logic [PAGE_W-1:0]       stop_pg,
    output logic [PAGE_W+OFF_W-1:0] addr_next
);
    localparam int ADDR_W = PAGE_W + OFF_W;

    logic [ADDR_W-1:0] inc;

    always_comb begin
        inc = addr + ADDR_W'(1);
        if (inc == {stop_pg, {OFF_W{1'b0}}}) begin
            addr_next = {start_pg, {OFF_W{1'b0}}};
        end else begin
            addr_next = inc;
        end
    end

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer #(
    parameter int PAGE_W    = 8,
    parameter int OFF_W     = 8,
    parameter int MAX_FRAME = 1514,
    parameter int MIN_FRAME = 60,
    parameter int HDR_BYTES = 4,
    parameter int CRC_BYTES = 4,
    parameter int LEN_W     = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic                    in_eof,
    input  logic [7:0]              in_data,
    input  logic                    stopped,
    input  logic [PAGE_W-1:0]       start_pg,
    input  logic [PAGE_W-1:0]       stop_pg,
    input  logic [PAGE_W-1:0]       bnd_pg,
    input  logic                    cur_set,
    input  logic [PAGE_W-1:0]       cur_val,
    output logic                    mem_we,
    output logic [PAGE_W+OFF_W-1:0] mem_addr,
    output logic [7:0]              mem_wdata,
    output logic [PAGE_W-1:0]       cur_pg,
    output logic [7:0]              rx_status,
    output logic                    rx_done,
    output logic                    ring_full,
    output logic                    frame_drop
);
    import rxr_pkg::*;

    localparam int ADDR_W     = PAGE_W + OFF_W;
    localparam int CNT_W      = $clog2(MAX_FRAME + 1);
    localparam int HI_W       = (HDR_BYTES > 1) ? $clog2(HDR_BYTES) : 1;
    localparam int NEED_BYTES = MAX_FRAME + HDR_BYTES;

    rxr_state_e state_q, state_d;

    logic [ADDR_W-1:0] wr_addr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HI_W-1:0]   hdr_idx_q;
    logic              grp_q;

    logic [ADDR_W-1:0] first_addr;
    logic [ADDR_W-1:0] step_addr;
    logic [ADDR_W-1:0] hdr_addr;
    logic [PAGE_W-1:0] next_pg;
    logic [LEN_W-1:0]  total_len;
    logic [7:0]        hdr_byte;
    logic [7:0]        frame_status;
    logic              sof_seen;
    logic              accept_ok;
    logic              take_frame;
    logic              hdr_last;
    logic              cnt_short_after;
    logic              single_short;

    // ---------------- helpers ----------------
    rxr_space_calc #(
        .PAGE_W     (PAGE_W),
        .OFF_W      (OFF_W),
        .NEED_BYTES (NEED_BYTES)
    ) space_i (
        .cur_pg   (cur_pg),
        .bnd_pg   (bnd_pg),
        .start_pg (start_pg),
        .stop_pg  (stop_pg),
        .full     (ring_full)
    );

    rxr_next_calc #(
        .PAGE_W    (PAGE_W),
        .OFF_W     (OFF_W),
        .LEN_W     (LEN_W),
        .CRC_BYTES (CRC_BYTES)
    ) next_i (
        .cur_pg    (cur_pg),
        .start_pg  (start_pg),
        .stop_pg   (stop_pg),
        .total_len (total_len),
        .next_pg   (next_pg)
    );

    rxr_addr_step #(
        .PAGE_W (PAGE_W),
        .OFF_W  (OFF_W)
    ) step_i (
        .addr      (mem_addr),
        .start_pg  (start_pg),
        .stop_pg   (stop_pg),
        .addr_next (step_addr)
    );

    // ---------------- shared decode ----------------
    always_comb begin
        sof_seen   = in_valid && in_sof
                     && ((state_q == ST_IDLE) || (state_q == ST_DONE));
        accept_ok  = !stopped && !ring_full;
        take_frame = sof_seen && accept_ok;
        first_addr = {cur_pg, OFF_W'(HDR_BYTES)};
        hdr_addr   = {cur_pg, OFF_W'(hdr_idx_q)};
        hdr_last   = (hdr_idx_q == HI_W'(HDR_BYTES - 1));
        total_len  = LEN_W'(cnt_q) + LEN_W'(HDR_BYTES);
        frame_status = rxr_status(grp_q);
        cnt_short_after = ({1'b0, cnt_q} + (CNT_W+1)'(1)) < (CNT_W+1)'(MIN_FRAME);
        single_short    = (MIN_FRAME > 1);
        case (hdr_idx_q)
            HI_W'(0): hdr_byte = frame_status;
            HI_W'(1): hdr_byte = 8'(next_pg);
            HI_W'(2): hdr_byte = total_len[7:0];
            default:  hdr_byte = total_len[15:8];
        endcase
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (sof_seen) begin
                    if (!accept_ok) begin
                        state_d = in_eof ? ST_IDLE : ST_SKIP;
                    end else if (in_eof) begin
                        state_d = single_short ? ST_PAD : ST_HDR;
                    end else begin
                        state_d = ST_DATA;
                    end
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_DATA: begin
                if (in_valid && in_eof) begin
                    state_d = cnt_short_after ? ST_PAD : ST_HDR;
                end
            end
            ST_SKIP: begin
                if (in_valid && in_eof) begin
                    state_d = ST_IDLE;
                end
            end
            ST_PAD: begin
                if (!cnt_short_after) begin
                    state_d = ST_HDR;
                end
            end
            ST_HDR: begin
                if (hdr_last) begin
                    state_d = ST_DONE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_addr_q <= '0;
            cnt_q     <= '0;
            hdr_idx_q <= '0;
            grp_q     <= 1'b0;
            cur_pg    <= '0;
            rx_status <= '0;
        end else begin
            if (take_frame) begin
                wr_addr_q <= step_addr;
                cnt_q     <= CNT_W'(1);
                hdr_idx_q <= '0;
                grp_q     <= in_data[0];
            end else if (((state_q == ST_DATA) && in_valid) || (state_q == ST_PAD)) begin
                wr_addr_q <= step_addr;
                cnt_q     <= cnt_q + CNT_W'(1);
            end else if (state_q == ST_HDR) begin
                hdr_idx_q <= hdr_idx_q + HI_W'(1);
            end

            if ((state_q == ST_HDR) && hdr_last) begin
                cur_pg    <= next_pg;
                rx_status <= frame_status;
            end else if (cur_set) begin
                cur_pg    <= cur_val;
            end
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        mem_we     = 1'b0;
        mem_addr   = wr_addr_q;
        mem_wdata  = in_data;
        rx_done    = 1'b0;
        frame_drop = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                rx_done = (state_q == ST_DONE);
                if (sof_seen) begin
                    if (accept_ok) begin
                        mem_we   = 1'b1;
                        mem_addr = first_addr;
                    end else begin
                        frame_drop = 1'b1;
                    end
                end
            end
            ST_DATA: begin
                mem_we = in_valid;
            end
            ST_SKIP: begin
                mem_we = 1'b0;
            end
            ST_PAD: begin
                mem_we    = 1'b1;
                mem_wdata = 8'h00;
            end
            ST_HDR: begin
                mem_we    = 1'b1;
                mem_addr  = hdr_addr;
                mem_wdata = hdr_byte;
            end
            default: mem_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/rxr_ring_writer_chk.sv
module rxr_ring_writer_chk #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    in_sof,
    input logic                    stopped,
    input rxr_pkg::rxr_state_e     state_q,
    input logic                    mem_we,
    input logic [PAGE_W+OFF_W-1:0] mem_addr,
    input logic [PAGE_W-1:0]       start_pg,
    input logic [PAGE_W-1:0]       stop_pg,
    input logic [PAGE_W-1:0]       cur_pg,
    input logic                    cur_set,
    input logic                    rx_done,
    input logic [7:0]              rx_status,
    input logic                    frame_drop
);
    import rxr_pkg::*;

    AST_WRITE_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[PAGE_W+OFF_W-1:OFF_W] >= start_pg)
                && (mem_addr[PAGE_W+OFF_W-1:OFF_W] < stop_pg)); // R1

    AST_DROP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_drop |-> !mem_we); // R3

    AST_STOP_REFUSES: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof && stopped
         && ((state_q == ST_IDLE) || (state_q == ST_DONE))) |-> frame_drop); // R3

    AST_DROP_KEEPS_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_drop && !cur_set) |=> $stable(cur_pg)); // R3

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> !rx_done); // R9

    AST_DONE_GOOD_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> rx_status[0]); // R8

    AST_PAGE_MOVE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cur_pg) |-> (rx_done || $past(cur_set))); // R11

endmodule

bind rxr_ring_writer rxr_ring_writer_chk #(
    .PAGE_W (PAGE_W),
    .OFF_W  (OFF_W)
) chk_i (.*);

// File: tb/rxr_ring_writer_tb_top.sv
`timescale 1ns/100ps
module rxr_ring_writer_tb_top;

    localparam int NEED = 1518;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        stopped = 1'b0;
    logic [7:0]  start_pg = 8'h40, stop_pg = 8'h50, bnd_pg = 8'h40;
    logic        cur_set = 1'b0;
    logic [7:0]  cur_val = 8'h00;
    logic        mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  cur_pg;
    logic [7:0]  rx_status;
    logic        rx_done, ring_full, frame_drop;

    rxr_ring_writer dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .stopped(stopped),
        .start_pg(start_pg), .stop_pg(stop_pg), .bnd_pg(bnd_pg),
        .cur_set(cur_set), .cur_val(cur_val), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_pg(cur_pg),
        .rx_status(rx_status), .rx_done(rx_done), .ring_full(ring_full),
        .frame_drop(frame_drop)
    );

    always #2.5 clk = ~clk;

    logic [7:0] fr [0:1599];
    logic [7:0] shadow [int];
    int  wr_cnt = 0;
    int  n_chk = 0, n_err = 0;
    bit  finished = 1'b0;
    int  m_cur = 0;
    int  m_start = 'h40, m_stop = 'h50;
    bit  last_done = 1'b0;

    // Write monitor, half a nanosecond before the rising edge.
    always @(negedge clk) begin
        #2;
        if (rst_n && mem_we) begin
            shadow[int'(mem_addr)] = mem_wdata;
            wr_cnt++;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int avail_of(input int cur, input int bnd);
        int c = cur * 256;
        int b = bnd * 256;
        if (c < b) return b - c;
        return (m_stop - m_start) * 256 - (c - b);
    endfunction

    function automatic int next_of(input int cur, input int tl);
        int nx = cur + (tl + 4 + 255) / 256;
        if (nx >= m_stop) nx -= (m_stop - m_start);
        return nx;
    endfunction

    function automatic int wrap_addr(input int a);
        if (a >= m_stop * 256) return a - (m_stop - m_start) * 256;
        return a;
    endfunction

    function automatic int rd(input int a);
        if (shadow.exists(a)) return int'(shadow[a]);
        return -1;
    endfunction

    task automatic fill_frame(input int len, input bit grp);
        for (int i = 0; i < len; i++) fr[i] = 8'($urandom);
        fr[0][0] = grp;
    endtask

    task automatic load_cur(input int v);
        @(negedge clk);
        cur_set = 1'b1;
        cur_val = 8'(v);
        @(negedge clk);
        cur_set = 1'b0;
        #1;
        check(cur_pg == 8'(v), "R11", "cur_pg after load", cur_pg, v);
        m_cur = v;
        last_done = 1'b0;
    endtask

    task automatic probe_full(input int cur, input int bnd, input string req);
        load_cur(cur);
        bnd_pg = 8'(bnd);
        #1;
        check(ring_full == (avail_of(cur, bnd) < NEED), req, "ring_full",
              ring_full, avail_of(cur, bnd) < NEED);
    endtask

    // Sends one frame; when now=1 the first byte is driven in the current
    // (rx_done) cycle of the previous frame.
    task automatic run_frame(input int len, input int bnd, input bit now, input string req);
        bit exp_full, exp_ref;
        int wr0, w, sz, tl, nx, st, a, bad_d, bad_p;
        if (!now) @(negedge clk);
        bnd_pg   = 8'(bnd);
        exp_full = avail_of(m_cur, bnd) < NEED;
        exp_ref  = stopped || exp_full;
        shadow.delete();
        wr0 = wr_cnt;
        in_valid = 1'b1; in_sof = 1'b1; in_eof = (len == 1); in_data = fr[0];
        #1;
        check(frame_drop == exp_ref, exp_ref ? "R3" : "R10", "frame_drop at start",
              frame_drop, exp_ref);
        check(ring_full == exp_full, "R2", "ring_full at start", ring_full, exp_full);
        for (int i = 1; i < len; i++) begin
            @(negedge clk);
            in_sof = 1'b0; in_data = fr[i]; in_eof = (i == len - 1);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_data = 8'h00;
        if (exp_ref) begin
            #1;
            check(wr_cnt == wr0, "R3", "writes of refused frame", wr_cnt - wr0, 0);
            check(cur_pg == 8'(m_cur), "R3", "cur_pg after refusal", cur_pg, m_cur);
            last_done = 1'b0;
            return;
        end
        w = 0;
        forever begin
            #1;
            if (rx_done) break;
            @(negedge clk);
            w++;
            if (w > 300) begin
                check(1'b0, "R9", "rx_done never seen", 0, 1);
                last_done = 1'b0;
                return;
            end
        end
        sz = (len < 60) ? 60 : len;
        tl = sz + 4;
        nx = next_of(m_cur, tl);
        st = fr[0][0] ? 'h21 : 'h01;
        check(cur_pg == 8'(nx), "R7", "cur_pg at rx_done", cur_pg, nx);
        check(rx_status == 8'(st), "R8", "rx_status", rx_status, st);
        check(rd(m_cur * 256) == st, "R6", "header status", rd(m_cur * 256), st);
        check(rd(m_cur * 256 + 1) == nx, "R6", "header next page", rd(m_cur * 256 + 1), nx);
        check(rd(m_cur * 256 + 2) == (tl & 'hff), "R6", "header len lo",
              rd(m_cur * 256 + 2), tl & 'hff);
        check(rd(m_cur * 256 + 3) == (tl >> 8), "R6", "header len hi",
              rd(m_cur * 256 + 3), tl >> 8);
        bad_d = -1; bad_p = -1;
        for (int k = 0; k < sz; k++) begin
            a = wrap_addr(m_cur * 256 + 4 + k);
            if (k < len) begin
                if (bad_d < 0 && rd(a) != int'(fr[k])) bad_d = k;
            end else begin
                if (bad_p < 0 && rd(a) != 0) bad_p = k;
            end
        end
        check(bad_d < 0, req, "data byte index mismatch", bad_d, -1);
        if (len < 60) check(bad_p < 0, "R5", "pad byte index nonzero", bad_p, -1);
        check(wr_cnt - wr0 == sz + 4, "R1", "write count", wr_cnt - wr0, sz + 4);
        m_cur = nx;
        last_done = 1'b1;
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "R9", "watchdog expired", 0, 1);
            finish_run();
        end
    end

    initial begin
        int len, bnd;
        bit grp;
        void'($urandom(32'd4242));
        // R12: reset state
        repeat (3) @(negedge clk);
        #1;
        check(cur_pg == 8'h00, "R12", "cur_pg in reset", cur_pg, 0);
        check(rx_status == 8'h00, "R12", "rx_status in reset", rx_status, 0);
        check(!mem_we && !rx_done && !frame_drop, "R12", "strobes in reset",
              {mem_we, rx_done, frame_drop}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        load_cur('h40);
        bnd_pg = 8'h40;

        // R3: stopped receiver refuses
        stopped = 1'b1;
        fill_frame(64, 1'b0);
        run_frame(64, 'h40, 1'b0, "R3");
        stopped = 1'b0;

        // R5 / R8: short frames, group bit both ways
        fill_frame(1, 1'b1);
        run_frame(1, m_cur, 1'b0, "R4");
        fill_frame(59, 1'b0);
        run_frame(59, m_cur, last_done, "R4");
        fill_frame(60, 1'b1);
        run_frame(60, m_cur, last_done, "R4");
        fill_frame(61, 1'b0);
        run_frame(61, m_cur, 1'b0, "R4");
        fill_frame(1514, 1'b0);
        run_frame(1514, m_cur, last_done, "R4");

        // R1: frame crossing the end of the ring
        load_cur('h4F);
        fill_frame(600, 1'b1);
        run_frame(600, 'h4F, 1'b0, "R1");

        // R2: full boundary on both sides
        probe_full('h48, 'h4E, "R2");
        probe_full('h48, 'h4D, "R2");
        probe_full('h4E, 'h43, "R2");
        probe_full('h4C, 'h43, "R2");

        // R3: refused frame with lagging boundary, then recovery
        load_cur('h48);
        fill_frame(100, 1'b0);
        run_frame(100, 'h4D, 1'b0, "R3");
        fill_frame(100, 1'b1);
        run_frame(100, 'h48, 1'b0, "R4");

        // Random mix: boundary sometimes lags, starts often in the done cycle (R10)
        bnd = m_cur;
        for (int n = 0; n < 40; n++) begin
            len = ($urandom_range(0, 7) == 0) ? $urandom_range(800, 1514)
                                              : $urandom_range(1, 300);
            grp = 1'($urandom_range(0, 1));
            fill_frame(len, grp);
            if ($urandom_range(0, 3) != 0) bnd = m_cur;
            run_frame(len, bnd, last_done && ($urandom_range(0, 1) == 1), "R10");
        end

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule